// File: doc/BRIEF.md
# Snooping Write-Back Cache Tag Unit

This block holds the tag, state and data of a small direct-mapped write-back cache. It serves two sides at once. The processor side looks lines up, installs new lines and updates cached words, which makes them dirty. The other side watches transfers on a shared memory bus driven by a DMA engine. It has its own read port into the tag array, so watching the bus never costs the processor a lookup cycle.

For each bus transfer it sees, the snoop logic picks one of three responses. It ignores the transfer, or it supplies its own copy of the line in place of memory, or it drops its copy. Only a dirty hit on a device read makes the cache supply data. A hit of any kind on a device write makes the cache drop the line, and any dirty data in that line is discarded because the device overwrites the whole line. When the processor tries to change a line that the bus is hitting in the same cycle, the bus side wins and the processor is told to try again.

Each line holds one data word. The address splits into an index (low bits) and a tag (high bits).

Top module: `snoop_tag_cache`

## Requirements
- R1: After reset every line is invalid. No processor lookup hits and no bus read raises `bus_inhibit`.
- R2: A processor fill (`cpu_op`=1) installs the tag and data as a clean line. A later lookup (`cpu_op`=0) of the same address has `cpu_hit`=1, returns the data on `cpu_rdata` and has `cpu_dirty`=0. An address with the same index and another tag misses.
- R3: A processor write (`cpu_op`=2) that hits replaces the data and marks the line dirty (`cpu_dirty`=1 on later hits). A write that misses changes nothing.
- R4: A bus read (`bus_valid`=1, `bus_write`=0) whose address is not cached has no effect: `bus_inhibit` stays 0 and `bus_data_valid` stays 0 in the next cycle.
- R5: A bus read that hits a clean line has no effect: no inhibit, no data, and the line stays valid and clean.
- R6: A bus read that hits a dirty line raises `bus_inhibit` in that same cycle. In the next cycle `bus_data_valid` is 1 and `bus_data` holds the line's data. The line stays valid and dirty.
- R7: A bus write (`bus_write`=1) that hits a clean line invalidates it. Later lookups of that address miss.
- R8: A bus write that hits a dirty line invalidates it and discards its data. Later lookups miss, and a later bus read of that address raises no inhibit.
- R9: A bus write whose address is not cached changes no line.
- R10: A processor fill or write to the index that a bus snoop hits in the same cycle raises `cpu_retry`. The processor access has no effect, and the snoop action is carried out.
- R11: Processor lookups in any cycle, and fills or writes to an index other than the one a snoop hits, proceed normally with `cpu_retry`=0, whatever the bus does in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 lookup, 1 fill, 2 write (3 acts as lookup) |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Fill or write data |
| cpu_hit | output | 1 | Request address is cached |
| cpu_dirty | output | 1 | Hit line is dirty |
| cpu_rdata | output | DATA_W | Data of the hit line |
| cpu_retry | output | 1 | Fill or write refused because of a same-index snoop hit |
| bus_valid | input | 1 | A bus transfer is observed this cycle |
| bus_write | input | 1 | 1 device-to-memory write, 0 memory-to-device read |
| bus_addr | input | ADDR_W | Bus transfer address |
| bus_inhibit | output | 1 | Memory must not drive data; the cache supplies it |
| bus_data | output | DATA_W | Intervention data, one cycle after inhibit |
| bus_data_valid | output | 1 | `bus_data` is being driven |

## Verification
Three things can fall in the same cycle: a processor fill or write, a processor lookup, and a snoop on the bus. Directed cycles pair a fill or write with a snoop hit on the same index. In those cycles `cpu_retry` must rise, and a later lookup must show that the processor's change was dropped while the invalidation or intervention went ahead. Other cycles pair the same processor requests with snoops on other indices or with missing tags, where nothing may be refused. A sweep then drives every combination of op, index and small tag on both ports together, and a bench model of the line array predicts each cycle's outputs.

// File: rtl/snoop_tag_pkg.sv
package snoop_tag_pkg;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_FILL   = 2'd1,
    OP_WRITE  = 2'd2
  } cpu_op_e;

  typedef enum logic [1:0] {
    SN_NONE      = 2'd0,
    SN_INTERVENE = 2'd1,
    SN_PURGE     = 2'd2
  } snoop_act_e;

endpackage

// File: rtl/snoop_line_store.sv
// Direct-mapped line array: tag, valid, dirty, data per line.
// Two combinational read ports (processor, snoop) and one merged update path.
module snoop_line_store #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor read port
  input  logic [IDX_W-1:0]  pr_idx,
  output logic              pr_valid,
  output logic [TAG_W-1:0]  pr_tag,
  output logic              pr_dirty,
  output logic [DATA_W-1:0] pr_data,
  // snoop read port
  input  logic [IDX_W-1:0]  sn_idx,
  output logic              sn_valid,
  output logic [TAG_W-1:0]  sn_tag,
  output logic              sn_dirty,
  output logic [DATA_W-1:0] sn_data,
  // processor update
  input  logic              up_en,
  input  logic              up_fill,
  input  logic [IDX_W-1:0]  up_idx,
  input  logic [TAG_W-1:0]  up_tag,
  input  logic [DATA_W-1:0] up_data,
  // snoop purge
  input  logic              pg_en,
  input  logic [IDX_W-1:0]  pg_idx
);

  localparam int LINES = 1 << IDX_W;

  logic              v_q   [LINES];
  logic              d_q   [LINES];
  logic [TAG_W-1:0]  t_q   [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              v_n, d_n, st_en, dat_en;
    logic [TAG_W-1:0]  t_n;
    logic              hit_up, hit_pg;

    assign hit_up = up_en && (up_idx == IDX_W'(i));
    assign hit_pg = pg_en && (pg_idx == IDX_W'(i));

    always_comb begin
      v_n = v_q[i];
      d_n = d_q[i];
      t_n = t_q[i];
      if (hit_up) begin
        if (up_fill) begin
          v_n = 1'b1;
          d_n = 1'b0;
          t_n = up_tag;
        end else begin
          d_n = 1'b1;
        end
      end
      // snoop purge has the last word
      if (hit_pg) begin
        v_n = 1'b0;
        d_n = 1'b0;
      end
    end

    assign st_en  = hit_up || hit_pg;
    assign dat_en = hit_up && !hit_pg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[i] <= 1'b0;
        d_q[i] <= 1'b0;
        t_q[i] <= '0;
      end else if (st_en) begin
        v_q[i] <= v_n;
        d_q[i] <= d_n;
        t_q[i] <= t_n;
      end
    end

    always_ff @(posedge clk) begin
      if (dat_en) begin
        dat_q[i] <= up_data;
      end
    end
  end

  assign pr_valid = v_q[pr_idx];
  assign pr_tag   = t_q[pr_idx];
  assign pr_dirty = d_q[pr_idx];
  assign pr_data  = dat_q[pr_idx];

  assign sn_valid = v_q[sn_idx];
  assign sn_tag   = t_q[sn_idx];
  assign sn_dirty = d_q[sn_idx];
  assign sn_data  = dat_q[sn_idx];

endmodule

// File: rtl/snoop_decide.sv
// Chooses the response to an observed bus transfer from the line state.
module snoop_decide
  import snoop_tag_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [TAG_W-1:0] bus_tag,
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             line_dirty,
  output logic             snoop_hit,
  output snoop_act_e       snoop_act
);

  assign snoop_hit = bus_valid && line_valid && (line_tag == bus_tag);

  always_comb begin
    snoop_act = SN_NONE;
    if (snoop_hit) begin
      if (bus_write)       snoop_act = SN_PURGE;
      else if (line_dirty) snoop_act = SN_INTERVENE;
    end
  end

endmodule

// File: rtl/cpu_access.sv
// Processor-side hit detection and update request, with retry on snoop conflict.
module cpu_access
  import snoop_tag_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic             cpu_valid,
  input  logic [1:0]       cpu_op,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic [TAG_W-1:0] cpu_tag,
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             snoop_hit,
  input  logic [IDX_W-1:0] snoop_idx,
  output logic             hit,
  output logic             retry,
  output logic             up_en,
  output logic             up_fill
);

  logic is_fill, is_write, conflict;

  assign is_fill  = cpu_valid && (cpu_op == OP_FILL);
  assign is_write = cpu_valid && (cpu_op == OP_WRITE);

  assign hit      = cpu_valid && line_valid && (line_tag == cpu_tag);
  assign conflict = snoop_hit && (snoop_idx == cpu_idx);
  assign retry    = (is_fill || is_write) && conflict;

  assign up_fill  = is_fill;
  assign up_en    = !retry && (is_fill || (is_write && hit));

endmodule

// File: rtl/snoop_tag_cache.sv
module snoop_tag_cache
  import snoop_tag_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_hit,
  output logic              cpu_dirty,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_retry,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_inhibit,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_data_valid
);

  localparam int TAG_W = ADDR_W - IDX_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0]  c_idx, s_idx;
  logic [TAG_W-1:0]  c_tag, s_tag;
  logic              pr_valid, pr_dirty, sn_valid, sn_dirty;
  logic [TAG_W-1:0]  pr_tag, sn_tag;
  logic [DATA_W-1:0] pr_data, sn_data;
  logic              s_hit, up_en, up_fill, c_hit;
  snoop_act_e        s_act;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = bus_addr[IDX_W-1:0];
  assign s_tag = bus_addr[ADDR_W-1:IDX_W];

  snoop_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pr_idx   (c_idx),
    .pr_valid (pr_valid),
    .pr_tag   (pr_tag),
    .pr_dirty (pr_dirty),
    .pr_data  (pr_data),
    .sn_idx   (s_idx),
    .sn_valid (sn_valid),
    .sn_tag   (sn_tag),
    .sn_dirty (sn_dirty),
    .sn_data  (sn_data),
    .up_en    (up_en),
    .up_fill  (up_fill),
    .up_idx   (c_idx),
    .up_tag   (c_tag),
    .up_data  (cpu_wdata),
    .pg_en    (s_act == SN_PURGE),
    .pg_idx   (s_idx)
  );

  snoop_decide #(.TAG_W(TAG_W)) u_decide (
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_tag    (s_tag),
    .line_valid (sn_valid),
    .line_tag   (sn_tag),
    .line_dirty (sn_dirty),
    .snoop_hit  (s_hit),
    .snoop_act  (s_act)
  );

  cpu_access #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_cpu (
    .cpu_valid  (cpu_valid),
    .cpu_op     (cpu_op),
    .cpu_idx    (c_idx),
    .cpu_tag    (c_tag),
    .line_valid (pr_valid),
    .line_tag   (pr_tag),
    .snoop_hit  (s_hit),
    .snoop_idx  (s_idx),
    .hit        (c_hit),
    .retry      (cpu_retry),
    .up_en      (up_en),
    .up_fill    (up_fill)
  );

  assign cpu_hit     = c_hit;
  assign cpu_dirty   = c_hit && pr_dirty;
  assign cpu_rdata   = pr_data;
  assign bus_inhibit = (s_act == SN_INTERVENE);

  // intervention data stage: data follows inhibit by one cycle
  logic              dv_n;
  logic [DATA_W-1:0] bd_q;

  assign dv_n = bus_inhibit;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) bus_data_valid <= 1'b0;
    else            bus_data_valid <= dv_n;
  end

  always_ff @(posedge clk) begin
    if (bus_inhibit) bd_q <= sn_data;
  end
  assign bus_data = bd_q;

endmodule

// File: rtl/snoop_tag_cache_chk.sv
module snoop_tag_cache_chk
  import snoop_tag_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic [1:0]        cpu_op,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_hit,
  input logic              cpu_dirty,
  input logic              cpu_retry,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_inhibit,
  input logic              bus_data_valid
);

  // R6: inhibit only during an observed bus read
  p_inhibit_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_inhibit |-> (bus_valid && !bus_write));

  // R6: data is driven in the cycle after inhibit
  p_data_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_inhibit |=> bus_data_valid);

  // R6: data is never driven without a preceding inhibit
  p_data_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_valid |-> $past(bus_inhibit));

  // R10: retry only while both ports are active
  p_retry_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_retry |-> (bus_valid && cpu_valid && (cpu_op == OP_FILL || cpu_op == OP_WRITE)));

  // R11: lookups never retry
  p_lookup_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_op == OP_LOOKUP) |-> !cpu_retry);

  // R3: dirty is reported only on a hit
  p_dirty_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_dirty |-> cpu_hit);

  // R7: after a bus write, a lookup of that address misses
  p_purge_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_valid && bus_write && !cpu_valid) && cpu_valid &&
     cpu_addr == $past(bus_addr)) |-> !cpu_hit);

endmodule

bind snoop_tag_cache snoop_tag_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_valid      (cpu_valid),
  .cpu_op         (cpu_op),
  .cpu_addr       (cpu_addr),
  .cpu_hit        (cpu_hit),
  .cpu_dirty      (cpu_dirty),
  .cpu_retry      (cpu_retry),
  .bus_valid      (bus_valid),
  .bus_write      (bus_write),
  .bus_addr       (bus_addr),
  .bus_inhibit    (bus_inhibit),
  .bus_data_valid (bus_data_valid)
);

// File: tb/sim_snoop_tag_cache.sv
`timescale 1ns/1ps
module sim_snoop_tag_cache;

  localparam int AW = 8;
  localparam int IW = 2;
  localparam int DW = 8;
  localparam int NL = 1 << IW;

  logic          clk, rst_n;
  logic          cpu_valid, cpu_hit, cpu_dirty, cpu_retry;
  logic [1:0]    cpu_op;
  logic [AW-1:0] cpu_addr, bus_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, bus_data;
  logic          bus_valid, bus_write, bus_inhibit, bus_data_valid;

  snoop_tag_cache #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_hit(cpu_hit), .cpu_dirty(cpu_dirty), .cpu_rdata(cpu_rdata), .cpu_retry(cpu_retry),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_inhibit(bus_inhibit), .bus_data(bus_data), .bus_data_valid(bus_data_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  string ctx = "init";

  // bench model of the line array
  logic          mv [NL];
  logic          md [NL];
  logic [AW-IW-1:0] mt [NL];
  logic [DW-1:0] mdat [NL];
  logic          e_dv;
  logic [DW-1:0] e_bd;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s (%s): actual %0h expected %0h", req, what, ctx, act, exp);
    end
  endtask

  task automatic step(input logic cv, input logic [1:0] op, input logic [AW-1:0] ca,
                      input logic [DW-1:0] wd, input logic bv, input logic bw,
                      input logic [AW-1:0] ba);
    logic [IW-1:0] ci, bi;
    logic [AW-IW-1:0] ct, bt;
    logic chit, shit, e_inh, e_rty, is_upd;
    @(negedge clk);
    // registered intervention outputs from the previous cycle
    check("R6", "bus_data_valid", 32'(bus_data_valid), 32'(e_dv));
    if (e_dv) check("R6", "bus_data", 32'(bus_data), 32'(e_bd));
    cpu_valid = cv; cpu_op = op; cpu_addr = ca; cpu_wdata = wd;
    bus_valid = bv; bus_write = bw; bus_addr = ba;
    #1;
    ci = ca[IW-1:0]; ct = ca[AW-1:IW];
    bi = ba[IW-1:0]; bt = ba[AW-1:IW];
    chit  = cv && mv[ci] && (mt[ci] == ct);
    shit  = bv && mv[bi] && (mt[bi] == bt);
    e_inh = shit && !bw && md[bi];
    is_upd = cv && (op == 2'd1 || op == 2'd2);
    e_rty = is_upd && shit && (bi == ci);
    check("R2", "cpu_hit", 32'(cpu_hit), 32'(chit));
    if (chit) begin
      check("R2", "cpu_rdata", 32'(cpu_rdata), 32'(mdat[ci]));
      check("R3", "cpu_dirty", 32'(cpu_dirty), 32'(md[ci]));
    end
    check(!shit ? "R4" : (md[bi] ? "R6" : "R5"), "bus_inhibit", 32'(bus_inhibit), 32'(e_inh));
    check(e_rty ? "R10" : "R11", "cpu_retry", 32'(cpu_retry), 32'(e_rty));
    // advance model
    e_dv = e_inh;
    if (e_inh) e_bd = mdat[bi];
    if (!e_rty && cv) begin
      if (op == 2'd1) begin
        mv[ci] = 1'b1; md[ci] = 1'b0; mt[ci] = ct; mdat[ci] = wd;
      end else if (op == 2'd2 && chit) begin
        md[ci] = 1'b1; mdat[ci] = wd;
      end
    end
    if (shit && bw) begin
      mv[bi] = 1'b0; md[bi] = 1'b0;
    end
    @(posedge clk);
  endtask

  function automatic logic [AW-1:0] mk(input int tag, input int idx);
    return AW'((tag << IW) | idx);
  endfunction

  task automatic idle();
    step(1'b0, 2'd0, '0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; mdat[i] = '0; end
    e_dv = 0; e_bd = '0;
    cpu_valid = 0; cpu_op = 0; cpu_addr = '0; cpu_wdata = '0;
    bus_valid = 0; bus_write = 0; bus_addr = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: everything misses after reset, no inhibit on bus reads
    ctx = "R1 reset";
    for (int i = 0; i < NL; i++) step(1'b1, 2'd0, mk(i + 1, i), '0, 1'b1, 1'b0, mk(i + 1, i));
    check("R1", "miss after reset", 32'(cpu_hit), 32'(0));

    // R2: fill every line, then look each up
    ctx = "R2 fill";
    for (int i = 0; i < NL; i++) step(1'b1, 2'd1, mk(i + 1, i), DW'(8'hA0 + i), 1'b0, 1'b0, '0);
    for (int i = 0; i < NL; i++) step(1'b1, 2'd0, mk(i + 1, i), '0, 1'b0, 1'b0, '0);
    for (int i = 0; i < NL; i++) step(1'b1, 2'd0, mk(i + 9, i), '0, 1'b0, 1'b0, '0);

    // R5 clean read hits, R4 read misses
    ctx = "R4 R5 bus read";
    for (int i = 0; i < NL; i++) step(1'b0, 2'd0, '0, '0, 1'b1, 1'b0, mk(i + 1, i));
    for (int i = 0; i < NL; i++) step(1'b0, 2'd0, '0, '0, 1'b1, 1'b0, mk(i + 20, i));
    idle();

    // R3: write hits on idx 0,1; write miss on idx 2
    ctx = "R3 write";
    step(1'b1, 2'd2, mk(1, 0), 8'h50, 1'b0, 1'b0, '0);
    step(1'b1, 2'd2, mk(2, 1), 8'h51, 1'b0, 1'b0, '0);
    step(1'b1, 2'd2, mk(30, 2), 8'h52, 1'b0, 1'b0, '0);
    for (int i = 0; i < NL; i++) step(1'b1, 2'd0, mk(i + 1, i), '0, 1'b0, 1'b0, '0);

    // R6 dirty read hits, concurrent lookups on other lines (R11)
    ctx = "R6 R11 intervene";
    step(1'b1, 2'd0, mk(3, 2), '0, 1'b1, 1'b0, mk(1, 0));
    step(1'b1, 2'd0, mk(4, 3), '0, 1'b1, 1'b0, mk(2, 1));
    step(1'b1, 2'd0, mk(1, 0), '0, 1'b1, 1'b0, mk(1, 0));
    idle();

    // R9: bus write miss leaves lines alone
    ctx = "R9 write miss";
    step(1'b0, 2'd0, '0, '0, 1'b1, 1'b1, mk(40, 0));
    step(1'b0, 2'd0, '0, '0, 1'b1, 1'b1, mk(41, 2));
    step(1'b1, 2'd0, mk(1, 0), '0, 1'b0, 1'b0, '0);
    step(1'b1, 2'd0, mk(3, 2), '0, 1'b0, 1'b0, '0);

    // R7 clean purge, R8 dirty purge
    ctx = "R7 R8 purge";
    step(1'b0, 2'd0, '0, '0, 1'b1, 1'b1, mk(3, 2));
    step(1'b0, 2'd0, '0, '0, 1'b1, 1'b1, mk(1, 0));
    step(1'b1, 2'd0, mk(3, 2), '0, 1'b1, 1'b0, mk(1, 0));
    step(1'b1, 2'd0, mk(1, 0), '0, 1'b1, 1'b0, mk(3, 2));
    check("R8", "lookup after dirty purge", 32'(cpu_hit), 32'(0));

    // R10: conflicts on the same index
    ctx = "R10 conflict";
    step(1'b1, 2'd1, mk(1, 0), 8'h77, 1'b0, 1'b0, '0);
    step(1'b1, 2'd2, mk(1, 0), 8'h78, 1'b1, 1'b1, mk(1, 0));
    step(1'b1, 2'd0, mk(1, 0), '0, 1'b0, 1'b0, '0);
    step(1'b1, 2'd1, mk(5, 1), 8'h79, 1'b1, 1'b0, mk(2, 1));
    step(1'b1, 2'd0, mk(2, 1), '0, 1'b0, 1'b0, '0);
    // R11: fill of another index while a snoop hits
    ctx = "R11 other index";
    step(1'b1, 2'd1, mk(6, 3), 8'h7A, 1'b1, 1'b0, mk(2, 1));
    step(1'b1, 2'd0, mk(6, 3), '0, 1'b0, 1'b0, '0);

    // sweep: every op, index and small tag against bus traffic
    ctx = "sweep";
    for (int a = 0; a < 1024; a++) begin
      logic [9:0] s;
      s = 10'(a);
      step(s[9] | s[0], 2'(a % 3), {4'd0, s[5:4], s[1:0]}, DW'(a * 7),
           s[0] | s[3], s[2] & s[6], {4'd0, s[3:2], s[7:6]});
    end
    idle();
    idle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule